// File: doc/BRIEF.md
# Read-Beat Parity Rebuild with Catch-Word Lane Location

This block sits on the read return path of a memory controller. The controller talks to nine memory devices. Each read beat brings eight 64-bit data lanes and one 64-bit parity lane, which holds the XOR of the data lanes. Each device has a fixed catch-word. A device sends its catch-word in place of its data when its internal detection logic finds an error it cannot trust. The block compares every lane with the catch-word of its device. That comparison shows which lane failed. The block then checks the XOR over all nine lanes. If one data lane carries its catch-word and the parity fails, the block rebuilds that lane from the other eight.

The block escalates when it cannot pinpoint the fault. If several lanes show catch-words, or the parity fails with no catch-word present, it asks for one re-read. It also raises `cw_off`, which tells the devices to stop substituting catch-words. If the parity still fails on the re-read, the beat is reported uncorrectable and a diagnosis request goes out. When a catch-word appears but the parity holds, the block treats it as real data that happens to equal the catch-word, and passes the beat through. On the write side the block produces the parity lane from the eight outgoing data lanes.

Top module: `xed_read_fix`

## Requirements
- R1: `wr_par` is the combinational XOR of the eight 64-bit lanes of `wr_lanes`. Lane i is held in bits [64*i+63 : 64*i].
- R2: A beat with good parity and no catch-word is captured on the first rising edge with `rd_valid` high. The next edge presents it on `out_lanes` unchanged, with `out_valid` high for exactly one cycle and all event flags low.
- R3: The catch-word of data lane i is `CW_SEED ^ i`, and the parity lane uses index 8. When exactly one data lane equals its catch-word and the nine-lane XOR is nonzero:
  - that lane is output as the XOR of the other eight lanes, parity lane included;
  - `out_fixed` is 1;
  - `out_lane_idx` gives the lane.
- R4: When any lane equals its catch-word but the nine-lane XOR is zero, the beat is passed unchanged with `out_collision` high.
- R5: On the first read, two or more catch-word matches give these results:
  - a one-cycle `retry_req` pulse, in the cycle where the output would otherwise appear;
  - `cw_off` goes high;
  - no `out_valid`.
- R6: On the first read, a nonzero nine-lane XOR with no catch-word present also produces the retry response of R5.
- R7: If the re-read beat still has a nonzero nine-lane XOR, it is passed unchanged with `out_uncorr` and `diag_req` high. No further retry is requested.
- R8: If the re-read beat has good parity, it is output as in R2. `cw_off` stays high through that output cycle and is low one cycle later.
- R9: When only the parity lane equals its catch-word (index 8) and the XOR is nonzero, the data lanes are passed unchanged with `out_parity_cw` high and `out_uncorr` low.
- R10: `rd_valid` is ignored while a captured beat is being checked or reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rd_valid | input | 1 | read beat present |
| rd_lanes | input | 512 | eight received data lanes |
| rd_par | input | 64 | received parity lane |
| wr_lanes | input | 512 | eight outgoing data lanes |
| wr_par | output | 64 | generated parity lane |
| out_valid | output | 1 | result beat present |
| out_lanes | output | 512 | corrected or passed data lanes |
| out_fixed | output | 1 | one lane was rebuilt |
| out_lane_idx | output | 3 | rebuilt lane index |
| out_collision | output | 1 | catch-word seen with good parity |
| out_parity_cw | output | 1 | parity lane carried its catch-word |
| out_uncorr | output | 1 | data uncorrectable after retry |
| diag_req | output | 1 | request device diagnosis |
| retry_req | output | 1 | request a re-read |
| cw_off | output | 1 | devices must not send catch-words |

## Verification
A table drives beats built from clean data with one of these changes applied:
- a catch-word on lane 0, lane 3 or lane 7, which checks rebuild and lane indexing at both ends;
- a catch-word standing in real data, which separates a collision from a fault;
- a catch-word on the parity lane only, which separates a parity-lane event from a data-lane rebuild;
- two catch-words, or a flipped bit with no catch-word, which separate the two causes of retry;
- a re-read that is clean or still corrupt, which separates recovery from device failure.

Directed tests cover write parity, the reset state, the fall of `cw_off`, and a `rd_valid` that is held high with changing data while the block is busy.

// File: rtl/xed_pkg.sv
package xed_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RETRY_WAIT,
      ST_REPORT
   } xed_state_e;

   typedef struct packed {
      logic fix;
      logic collide;
      logic parhit;
      logic retry;
      logic fail;
   } xed_verdict_t;

endpackage

// File: rtl/xed_lane_xor.sv
module xed_lane_xor #(
   parameter int N = 8,
   parameter int W = 64
) (
   input  logic [N*W-1:0] lanes_i,
   output logic [W-1:0]   sum_o
);

   always_comb begin
      sum_o = '0;
      for (int i = 0; i < N; i++) begin
         sum_o = sum_o ^ lanes_i[i*W +: W];
      end
   end

endmodule

// File: rtl/xed_cw_match.sv
module xed_cw_match #(
   parameter int             LANES   = 8,
   parameter int             W       = 64,
   parameter int             IDXW    = 3,
   parameter logic [W-1:0]   CW_SEED = '0
) (
   input  logic [LANES*W-1:0] data_i,
   input  logic [W-1:0]       par_i,
   output logic [LANES:0]     hit_o,
   output logic [IDXW-1:0]    idx_o,
   output logic               multi_o
);

   localparam int NL = LANES + 1;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign hit_o[i] = (data_i[i*W +: W] == (CW_SEED ^ W'(i)));
   end
   assign hit_o[LANES] = (par_i == (CW_SEED ^ W'(LANES)));

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < LANES; i++) begin
         if (hit_o[i]) idx_o = IDXW'(i);
      end
   end

   assign multi_o = |(hit_o & (hit_o - NL'(1)));

endmodule

// File: rtl/xed_rebuild.sv
module xed_rebuild #(
   parameter int LANES = 8,
   parameter int W     = 64,
   parameter int IDXW  = 3
) (
   input  logic [LANES*W-1:0] data_i,
   input  logic [W-1:0]       syn_i,
   input  logic [IDXW-1:0]    idx_i,
   input  logic               en_i,
   output logic [LANES*W-1:0] data_o
);

   // lane ^ (XOR of all nine) equals the XOR of the other eight
   for (genvar i = 0; i < LANES; i++) begin : g_fix
      assign data_o[i*W +: W] = (en_i && (idx_i == IDXW'(i)))
                                ? (data_i[i*W +: W] ^ syn_i)
                                : data_i[i*W +: W];
   end

endmodule

// File: rtl/xed_read_fix.sv
module xed_read_fix
   import xed_pkg::*;
#(
   parameter int           LANES   = 8,
   parameter int           W       = 64,
   parameter logic [W-1:0] CW_SEED = W'(64'hC3A5_96F0_0F69_5A3C)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_valid,
   input  logic [LANES*W-1:0]         rd_lanes,
   input  logic [W-1:0]               rd_par,
   input  logic [LANES*W-1:0]         wr_lanes,
   output logic [W-1:0]               wr_par,
   output logic                       out_valid,
   output logic [LANES*W-1:0]         out_lanes,
   output logic                       out_fixed,
   output logic [$clog2(LANES)-1:0]   out_lane_idx,
   output logic                       out_collision,
   output logic                       out_parity_cw,
   output logic                       out_uncorr,
   output logic                       diag_req,
   output logic                       retry_req,
   output logic                       cw_off
);

   localparam int IDXW = $clog2(LANES);
   localparam int DW   = LANES * W;

   if (LANES < 2) begin : g_bad_lanes
      $error("xed_read_fix: LANES must be at least 2");
   end
   if (W < IDXW + 2) begin : g_bad_width
      $error("xed_read_fix: W too narrow for distinct catch-words");
   end

   xed_state_e           state;
   logic [DW-1:0]        cap_data;
   logic [W-1:0]         cap_par;
   logic                 retried;
   logic [W-1:0]         syn;
   logic [LANES:0]       hit;
   logic [IDXW-1:0]      hit_idx;
   logic                 multi;
   logic [DW-1:0]        fixed_data;
   xed_verdict_t         vd;

   // write side parity
   xed_lane_xor #(.N(LANES), .W(W)) u_wr_xor (
      .lanes_i (wr_lanes),
      .sum_o   (wr_par)
   );

   // nine-lane syndrome of the captured beat
   xed_lane_xor #(.N(LANES + 1), .W(W)) u_rd_xor (
      .lanes_i ({cap_par, cap_data}),
      .sum_o   (syn)
   );

   xed_cw_match #(.LANES(LANES), .W(W), .IDXW(IDXW), .CW_SEED(CW_SEED)) u_match (
      .data_i  (cap_data),
      .par_i   (cap_par),
      .hit_o   (hit),
      .idx_o   (hit_idx),
      .multi_o (multi)
   );

   xed_rebuild #(.LANES(LANES), .W(W), .IDXW(IDXW)) u_fix (
      .data_i  (cap_data),
      .syn_i   (syn),
      .idx_i   (hit_idx),
      .en_i    (vd.fix),
      .data_o  (fixed_data)
   );

   always_comb begin
      logic par_bad;
      logic any_hit;
      logic data_hit;
      par_bad  = |syn;
      any_hit  = |hit;
      data_hit = |hit[LANES-1:0];
      vd       = '0;
      if (retried) begin
         if (par_bad)      vd.fail    = 1'b1;
         else if (any_hit) vd.collide = 1'b1;
      end else if (multi) begin
         vd.retry = 1'b1;
      end else if (!par_bad) begin
         vd.collide = any_hit;
      end else if (data_hit) begin
         vd.fix = 1'b1;
      end else if (hit[LANES]) begin
         vd.parhit = 1'b1;
      end else begin
         vd.retry = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         cap_data      <= '0;
         cap_par       <= '0;
         retried       <= 1'b0;
         out_valid     <= 1'b0;
         out_lanes     <= '0;
         out_fixed     <= 1'b0;
         out_lane_idx  <= '0;
         out_collision <= 1'b0;
         out_parity_cw <= 1'b0;
         out_uncorr    <= 1'b0;
         diag_req      <= 1'b0;
         retry_req     <= 1'b0;
         cw_off        <= 1'b0;
      end else begin
         out_valid     <= 1'b0;
         out_fixed     <= 1'b0;
         out_lane_idx  <= '0;
         out_collision <= 1'b0;
         out_parity_cw <= 1'b0;
         out_uncorr    <= 1'b0;
         diag_req      <= 1'b0;
         retry_req     <= 1'b0;
         case (state)
            ST_IDLE, ST_RETRY_WAIT: begin
               if (rd_valid) begin
                  cap_data <= rd_lanes;
                  cap_par  <= rd_par;
                  state    <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (vd.retry) begin
                  retry_req <= 1'b1;
                  cw_off    <= 1'b1;
                  retried   <= 1'b1;
                  state     <= ST_RETRY_WAIT;
               end else begin
                  out_valid     <= 1'b1;
                  out_lanes     <= fixed_data;
                  out_fixed     <= vd.fix;
                  out_lane_idx  <= vd.fix ? hit_idx : '0;
                  out_collision <= vd.collide;
                  out_parity_cw <= vd.parhit;
                  out_uncorr    <= vd.fail;
                  diag_req      <= vd.fail;
                  state         <= ST_REPORT;
               end
            end
            ST_REPORT: begin
               cw_off  <= 1'b0;
               retried <= 1'b0;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5
   retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |=> !retry_req);

   // R5
   retry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> (!out_valid && cw_off));

   // R7
   uncorr_after_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_uncorr |-> (out_valid && cw_off && diag_req));

   // R3
   fixed_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fixed |-> out_valid);

   // R2
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_fixed, out_collision, out_parity_cw, out_uncorr}));

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> (!out_valid && !retry_req));

   // R8
   cw_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cw_off) |-> $past(out_valid));

endmodule

// File: tb/xed_read_fix_test.sv
module xed_read_fix_test;

   localparam int          L  = 8;
   localparam int          W  = 64;
   localparam logic [63:0] CW = 64'hC3A5_96F0_0F69_5A3C;

   typedef struct packed {
      logic [63:0] seed;
      logic [8:0]  mask;
      logic        coll;
      logic [63:0] flip;
      logic [2:0]  kind;   // 0 clean 1 fix 2 collide 3 parhit 4 retry-ok 5 retry-fail
      logic [2:0]  idx;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{64'h0123_4567_89AB_CDEF, 9'h000, 1'b0, 64'h0,  3'd0, 3'd0},
      '{64'h1111_2222_3333_4444, 9'h008, 1'b0, 64'h0,  3'd1, 3'd3},
      '{64'h5A5A_0000_FFFF_1234, 9'h001, 1'b0, 64'h0,  3'd1, 3'd0},
      '{64'hDEAD_BEEF_0BAD_F00D, 9'h080, 1'b0, 64'h0,  3'd1, 3'd7},
      '{64'h7777_1234_AAAA_0001, 9'h020, 1'b1, 64'h0,  3'd2, 3'd0},
      '{64'h0F0F_3C3C_9999_4321, 9'h100, 1'b0, 64'h0,  3'd3, 3'd0},
      '{64'h2468_ACE0_1357_9BDF, 9'h044, 1'b0, 64'h0,  3'd4, 3'd0},
      '{64'h8000_0000_0000_0001, 9'h000, 1'b0, 64'h10, 3'd5, 3'd0},
      '{64'h4242_4242_1010_2020, 9'h012, 1'b0, 64'h0,  3'd5, 3'd0},
      '{64'h3141_5926_5358_9793, 9'h000, 1'b0, 64'h4,  3'd4, 3'd0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rd_valid = 1'b0;
   logic [L*W-1:0]  rd_lanes = '0;
   logic [W-1:0]    rd_par = '0;
   logic [L*W-1:0]  wr_lanes = '0;
   logic [W-1:0]    wr_par;
   logic            out_valid;
   logic [L*W-1:0]  out_lanes;
   logic            out_fixed;
   logic [2:0]      out_lane_idx;
   logic            out_collision;
   logic            out_parity_cw;
   logic            out_uncorr;
   logic            diag_req;
   logic            retry_req;
   logic            cw_off;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   xed_read_fix #(.LANES(L), .W(W), .CW_SEED(CW)) uut (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_lanes(rd_lanes),
      .rd_par(rd_par), .wr_lanes(wr_lanes), .wr_par(wr_par),
      .out_valid(out_valid), .out_lanes(out_lanes), .out_fixed(out_fixed),
      .out_lane_idx(out_lane_idx), .out_collision(out_collision),
      .out_parity_cw(out_parity_cw), .out_uncorr(out_uncorr),
      .diag_req(diag_req), .retry_req(retry_req), .cw_off(cw_off)
   );

   function automatic logic [63:0] cw_of(input int i);
      return CW ^ 64'(i);
   endfunction

   function automatic logic [63:0] xor8(input logic [L*W-1:0] d);
      logic [63:0] s = '0;
      for (int i = 0; i < L; i++) s ^= d[i*W +: W];
      return s;
   endfunction

   function automatic logic [L*W-1:0] mk_lanes(input logic [63:0] seed);
      logic [L*W-1:0] d;
      for (int i = 0; i < L; i++)
         d[i*W +: W] = (seed * 64'(i + 3)) ^ (64'h9E37_79B9_7F4A_7C15 << i);
      return d;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] flags();
      return {out_valid, out_fixed, out_collision, out_parity_cw,
              out_uncorr, diag_req, retry_req};
   endfunction

   task automatic send(input logic [L*W-1:0] d, input logic [63:0] p);
      @(negedge clk);
      rd_valid = 1'b1;
      rd_lanes = d;
      rd_par   = p;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [L*W-1:0] clean, lanes, rl, ed, la, lb;
      logic [63:0]    par, rp;
      logic [6:0]     ef;
      string          tg;

      repeat (3) @(negedge clk);
      chk(flags() == 7'd0 && cw_off == 1'b0, "R2 reset",
          {flags(), cw_off}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(flags() == 7'd0 && cw_off == 1'b0, "R2 after reset",
          {flags(), cw_off}, '0);

      // R1 write parity, two patterns
      wr_lanes = mk_lanes(64'hABCD_0123_4567_89EF);
      #1;
      chk(wr_par == xor8(wr_lanes), "R1 pattern a", wr_par, xor8(wr_lanes));
      wr_lanes = {L{64'hFFFF_0000_FFFF_0000}};
      #1;
      chk(wr_par == 64'h0, "R1 pattern b", wr_par, 0);

      foreach (VECS[v]) begin
         clean = mk_lanes(VECS[v].seed);
         lanes = clean;
         if (VECS[v].coll) begin
            for (int i = 0; i < L; i++)
               if (VECS[v].mask[i]) lanes[i*W +: W] = cw_of(i);
            par = xor8(lanes);
         end else begin
            par = xor8(clean);
            for (int i = 0; i < L; i++)
               if (VECS[v].mask[i]) lanes[i*W +: W] = cw_of(i);
            if (VECS[v].mask[8]) par = cw_of(8);
         end
         lanes[W +: W] = lanes[W +: W] ^ VECS[v].flip;

         send(lanes, par);
         @(negedge clk);

         if (VECS[v].kind >= 3'd4) begin
            tg = ($countones(VECS[v].mask) >= 2) ? "R5 multi catch-word retry"
                                                 : "R6 bad parity no catch-word retry";
            chk(retry_req && !out_valid && cw_off, tg,
                {flags(), cw_off}, {7'b0000001, 1'b1});
            rl = clean;
            if (VECS[v].kind == 3'd5) rl[0] = ~rl[0];
            rp = xor8(clean);
            send(rl, rp);
            @(negedge clk);
            if (VECS[v].kind == 3'd5) begin
               ef = 7'b1000110;
               tg = "R7 retry still bad";
            end else begin
               ef = 7'b1000000;
               tg = "R8 retry recovers";
            end
            chk(flags() == ef, tg, flags(), ef);
            chk(out_lanes == rl, tg, out_lanes, rl);
            @(negedge clk);
            chk(cw_off == 1'b0 && !retry_req && !out_valid, "R8 cw_off released",
                {cw_off, retry_req, out_valid}, 0);
         end else begin
            case (VECS[v].kind)
               3'd0: begin ef = 7'b1000000; ed = lanes; tg = "R2 clean beat"; end
               3'd1: begin ef = 7'b1100000; ed = clean; tg = "R3 lane rebuild"; end
               3'd2: begin ef = 7'b1010000; ed = lanes; tg = "R4 collision"; end
               default: begin ef = 7'b1001000; ed = lanes; tg = "R9 parity lane catch-word"; end
            endcase
            chk(flags() == ef, tg, flags(), ef);
            chk(out_lanes == ed, tg, out_lanes, ed);
            if (VECS[v].kind == 3'd1)
               chk(out_lane_idx == VECS[v].idx, "R3 lane index",
                   out_lane_idx, VECS[v].idx);
            @(negedge clk);
         end
      end

      // R10 rd_valid held through check and report with other data
      la = mk_lanes(64'h1234_5678_9ABC_DEF0);
      lb = mk_lanes(64'h0FED_CBA9_8765_4321);
      @(negedge clk);
      rd_valid = 1'b1; rd_lanes = la; rd_par = xor8(la);
      @(negedge clk);
      rd_lanes = lb; rd_par = xor8(lb);
      @(negedge clk);
      chk(out_valid && out_lanes == la, "R10 first beat kept", out_lanes, la);
      @(negedge clk);
      rd_valid = 1'b0;
      chk(!out_valid, "R10 no output in report", out_valid, 0);
      @(negedge clk);
      chk(!out_valid && !retry_req, "R10 busy beat dropped",
          {out_valid, retry_req}, 0);
      @(negedge clk);
      chk(!out_valid, "R10 no late output", out_valid, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule